// File: doc/BRIEF.md
# Window-Lockable Byte Storage Port

This block is a byte-wide storage array reached through a latched pointer. A set-pointer strobe captures an address, and every later read or write uses that captured address until the next load. Writes take a 32-bit word and keep only its low byte. Reads are registered: the byte appears one cycle after the read strobe, together with a valid flag.

Two adjacent 16-byte windows near the bottom of the array can each be protected by its own lock bit. A lock bit is never written directly. A toggle strobe with a lock index inverts the selected bit. While a window is protected, reads of it return 0xFF and writes to it are dropped. The address space also has an unbacked hole and an upper limit. Any access that falls there is refused in the same way. A typical use is a configuration store in which a host shields two small identity records from stray writes.

Top module: `nvl_top`

## Requirements
- R1: A cycle with `addr_ld` high captures `addr_in` as the access pointer at the clock edge. A read or write in that same cycle still uses the pointer held before the edge.
- R2: A cycle with `lock_tgl` high inverts lock bit `lock_idx`, and no other lock bit changes. Both lock bits are 0 after reset, so both windows start open.
- R3: Lock bit 0 protects addresses 0x020 to 0x02F, and lock bit 1 protects 0x030 to 0x03F. Addresses outside the window of a set bit, such as 0x01F next to window 0, are not affected.
- R4: A read of a protected address returns 0xFF. A write to a protected address leaves the stored byte unchanged, which can be seen once the window is opened again.
- R5: With default parameters, an address is legal when it is below 0x300, or when it is from 0x380 up to 0x3FF. Reads of any other address return 0xFF, and writes to them change nothing, including the location that shares their low address bits.
- R6: A permitted write stores bits [7:0] of `wr_data` and ignores bits [31:8].
- R7: `rd_data` and `rd_valid` change on the clock edge after a cycle with `rd_en` high, and `rd_valid` is high for exactly that one cycle. `rd_data` holds its value in the cycles between reads.
- R8: A lock toggle in the same cycle as an access is applied after the access. The access is judged against the lock state held before the edge.
- R9: A read and a write to the same permitted address in one cycle return the byte stored before that write. The new byte is stored.
- R10: After reset, `rd_valid` is 0, `rd_data` is 0xFF, and the pointer is 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_ld | input | 1 | Load `addr_in` into the access pointer |
| addr_in | input | 16 | New pointer value |
| lock_tgl | input | 1 | Invert the lock bit chosen by `lock_idx` |
| lock_idx | input | 1 | Lock bit index |
| wr_en | input | 1 | Write the low byte of `wr_data` at the pointer |
| wr_data | input | 32 | Write word; only bits [7:0] are kept |
| rd_en | input | 1 | Read the byte at the pointer |
| rd_data | output | 8 | Registered read byte, or 0xFF when refused |
| rd_valid | output | 1 | High in the cycle after a read strobe |

## Verification
The bench drives a lock toggle in the same cycle as a read or write inside the affected window. It also loads a new pointer in the same cycle as an access, and reads and writes one address in a single cycle. Each same-cycle case is judged against a reference model that first evaluates the access with the old pointer, old lock state and old contents, and only then applies the load, the toggle or the write. The following read of the same address shows whether the deferred update landed.

// File: rtl/nvl_pkg.sv
package nvl_pkg;

    parameter int unsigned NVL_AW    = 16;
    parameter int unsigned NVL_NLOCK = 2;
    parameter int unsigned NVL_LIW   = (NVL_NLOCK > 1) ? $clog2(NVL_NLOCK) : 1;

    typedef struct packed {
        logic [NVL_AW-1:0] ptr;
        logic              rd_valid;
    } nvl_port_t;

    typedef struct packed {
        logic [NVL_NLOCK-1:0] bits;
    } nvl_lock_t;

    typedef struct packed {
        logic [7:0] data;
    } nvl_rd_t;

endpackage

// File: rtl/nvl_lockreg.sv
module nvl_lockreg
    import nvl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tgl,
    input  logic [NVL_LIW-1:0] idx,
    output logic [NVL_NLOCK-1:0] lock
);

    nvl_lock_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (tgl && (32'(idx) < NVL_NLOCK)) begin
            lk_d.bits[idx] = ~lk_q.bits[idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assign lock = lk_q.bits;

    for (genvar i = 0; i < NVL_NLOCK; i++) begin : g_lock_chk
        // R2: the selected bit inverts
        p_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (tgl && 32'(idx) == i) |=> (lock[i] != $past(lock[i])));
        // R2: unselected bits hold
        p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(tgl && 32'(idx) == i) |=> $stable(lock[i]));
    end

endmodule

// File: rtl/nvl_decode.sv
module nvl_decode
    import nvl_pkg::*;
#(
    parameter int unsigned DEPTH      = 1024,
    parameter int unsigned LOW_LIMIT  = 'h300,
    parameter int unsigned HIGH_START = 'h380,
    parameter int unsigned WIN_BASE   = 'h20,
    parameter int unsigned WIN_SIZE   = 16
) (
    input  logic [NVL_AW-1:0]    addr,
    input  logic [NVL_NLOCK-1:0] lock,
    output logic                 permit
);

    localparam logic [NVL_AW:0] LO_LIM = (NVL_AW+1)'(LOW_LIMIT < DEPTH ? LOW_LIMIT : DEPTH);
    localparam logic [NVL_AW:0] HI_BEG = (NVL_AW+1)'(HIGH_START);
    localparam logic [NVL_AW:0] TOP    = (NVL_AW+1)'(DEPTH);

    logic [NVL_AW:0]      a_ext;
    logic                 legal;
    logic [NVL_NLOCK-1:0] hit;

    assign a_ext = {1'b0, addr};

    always_comb begin
        legal = (a_ext < LO_LIM) || ((a_ext >= HI_BEG) && (a_ext < TOP));
    end

    for (genvar i = 0; i < NVL_NLOCK; i++) begin : g_win
        localparam logic [NVL_AW:0] W_LO = (NVL_AW+1)'(WIN_BASE + i * WIN_SIZE);
        localparam logic [NVL_AW:0] W_HI = (NVL_AW+1)'(WIN_BASE + (i + 1) * WIN_SIZE);
        assign hit[i] = lock[i] && (a_ext >= W_LO) && (a_ext < W_HI);
    end

    assign permit = legal && !(|hit);

endmodule

// File: rtl/nvl_array.sv
module nvl_array
    import nvl_pkg::*;
#(
    parameter int unsigned DEPTH = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NVL_AW-1:0] addr,
    input  logic              wr_ok,
    input  logic [7:0]        wr_byte,
    input  logic              rd_en,
    input  logic              rd_ok,
    output logic [7:0]        rd_data
);

    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]       mem [DEPTH];
    logic [IDX_W-1:0] idx;
    nvl_rd_t          rd_d, rd_q;

    assign idx = addr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[idx] <= wr_byte;
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) rd_d.data = rd_ok ? mem[idx] : 8'hFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '{data: 8'hFF};
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q.data;

    // R7: read byte holds between reads
    p_hold_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/nvl_top.sv
module nvl_top
    import nvl_pkg::*;
#(
    parameter int unsigned DEPTH      = 1024,
    parameter int unsigned LOW_LIMIT  = 'h300,
    parameter int unsigned HIGH_START = 'h380,
    parameter int unsigned WIN_BASE   = 'h20,
    parameter int unsigned WIN_SIZE   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_ld,
    input  logic [NVL_AW-1:0]  addr_in,
    input  logic               lock_tgl,
    input  logic [NVL_LIW-1:0] lock_idx,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    input  logic               rd_en,
    output logic [7:0]         rd_data,
    output logic               rd_valid
);

    nvl_port_t            st_d, st_q;
    logic [NVL_NLOCK-1:0] lock;
    logic                 permit;

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = rd_en;
        if (addr_ld) st_d.ptr = addr_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    nvl_lockreg u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .tgl   (lock_tgl),
        .idx   (lock_idx),
        .lock  (lock)
    );

    nvl_decode #(
        .DEPTH      (DEPTH),
        .LOW_LIMIT  (LOW_LIMIT),
        .HIGH_START (HIGH_START),
        .WIN_BASE   (WIN_BASE),
        .WIN_SIZE   (WIN_SIZE)
    ) u_dec (
        .addr   (st_q.ptr),
        .lock   (lock),
        .permit (permit)
    );

    nvl_array #(
        .DEPTH (DEPTH)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (st_q.ptr),
        .wr_ok   (wr_en && permit),
        .wr_byte (wr_data[7:0]),
        .rd_en   (rd_en),
        .rd_ok   (permit),
        .rd_data (rd_data)
    );

    assign rd_valid = st_q.rd_valid;

    // R7: valid follows a read strobe by one cycle
    p_valid_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    // R7: no valid without a read strobe
    p_no_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    // R4: refused reads return all ones
    p_denied_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !permit) |=> (rd_data == 8'hFF));

endmodule

// File: tb/tb_nvl_top.sv
`timescale 1ns/1ps
module tb_nvl_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_ld = 1'b0;
    logic [15:0] addr_in = '0;
    logic        lock_tgl = 1'b0;
    logic [0:0]  lock_idx = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid;

    always #2 clk = ~clk;

    nvl_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_ld  (addr_ld),
        .addr_in  (addr_in),
        .lock_tgl (lock_tgl),
        .lock_idx (lock_idx),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    typedef struct {
        logic [7:0]  data;
        int unsigned addr;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    // reference model state
    logic [7:0]  m_mem [int];
    int unsigned m_ptr = 0;
    bit [1:0]    m_lock = 2'b00;

    function automatic bit legal(int unsigned a);
        return (a < 'h300) || (a >= 'h380 && a < 'h400);
    endfunction

    function automatic bit guarded(int unsigned a);
        return (m_lock[0] && a >= 'h20 && a <= 'h2F) ||
               (m_lock[1] && a >= 'h30 && a <= 'h3F);
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one cycle, model evaluated with pre-edge state
    task automatic op(bit ld, int unsigned a, bit wr, logic [31:0] wd,
                      bit rd, bit tg, bit ix, string tag);
        bit   ok;
        exp_t e;
        ok = legal(m_ptr) && !guarded(m_ptr);
        if (rd) begin
            e.addr = m_ptr;
            e.tag  = tag;
            if (!ok)                      e.data = 8'hFF;
            else if (m_mem.exists(m_ptr)) e.data = m_mem[m_ptr];
            else                          e.data = 8'hxx;
            exp_q.push_back(e);
        end
        if (wr && ok) m_mem[m_ptr] = wd[7:0];
        if (ld) m_ptr = a;
        if (tg) m_lock[ix] = ~m_lock[ix];
        addr_ld  = ld;
        addr_in  = a[15:0];
        wr_en    = wr;
        wr_data  = wd;
        rd_en    = rd;
        lock_tgl = tg;
        lock_idx = ix;
        @(negedge clk);
        addr_ld  = 1'b0;
        wr_en    = 1'b0;
        rd_en    = 1'b0;
        lock_tgl = 1'b0;
    endtask

    task automatic point(int unsigned a);
        op(1, a, 0, 0, 0, 0, 0, "");
    endtask
    task automatic put(int unsigned a, logic [31:0] d);
        point(a);
        op(0, 0, 1, d, 0, 0, 0, "");
    endtask
    task automatic get(int unsigned a, string tag);
        point(a);
        op(0, 0, 0, 0, 1, 0, 0, tag);
    endtask
    task automatic flip(bit ix);
        op(0, 0, 0, 0, 0, 1, ix, "");
    endtask

    // monitor: compares each valid read against the queue head
    always @(negedge clk) begin
        if (rst_n && !done && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected valid", {24'h0, rd_data}, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rd_data === e.data, $sformatf("%s @%h", e.tag, e.addr),
                      {24'h0, rd_data}, {24'h0, e.data});
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(rd_valid === 1'b0, "R10 rd_valid", {31'h0, rd_valid}, 0);
        check(rd_data === 8'hFF, "R10 rd_data", {24'h0, rd_data}, 32'hFF);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: pointer 0 after reset
        op(0, 0, 1, 32'h0000_0077, 0, 0, 0, "");
        get(0, "R10 pointer zero");

        // R6 and R2 (windows start open): basic storage
        put('h025, 32'hDEAD_BE5A);
        put('h2FF, 32'h1234_5601);
        put('h380, 32'hFFFF_FF80);
        put('h3FF, 32'h0000_00C3);
        put('h010, 32'h0000_0011);
        put('h035, 32'h0000_0035);
        put('h01F, 32'h0000_001F);
        get('h025, "R6 low byte / R2 open at reset");
        get('h2FF, "R5 top of low range");
        get('h380, "R5 start of high range");
        get('h3FF, "R5 last location");

        // R5: hole and beyond-depth addresses
        put('h300, 32'h0000_00AA);
        get('h300, "R5 hole start");
        put('h37F, 32'h0000_00AB);
        get('h37F, "R5 hole end");
        put('h410, 32'h0000_00EE);
        get('h410, "R5 beyond depth");
        get('h010, "R5 no alias write");

        // R3/R4: lock window 0
        flip(0);
        get('h020, "R3 window0 low edge");
        get('h02F, "R3 window0 high edge");
        get('h01F, "R3 outside window0");
        get('h035, "R3 window1 open");
        put('h025, 32'h0000_0099);
        flip(1);
        get('h035, "R3 window1 locked");
        flip(0);
        get('h025, "R4 write dropped while locked");

        // R8: toggle in same cycle as access
        point('h035);
        op(0, 0, 0, 0, 1, 1, 1, "R8 read with unlocking toggle");
        op(0, 0, 0, 0, 1, 0, 0, "R8 read after toggle");
        point('h028);
        op(0, 0, 1, 32'h0000_0042, 0, 1, 0, "");
        flip(0);
        get('h028, "R8 write before locking toggle");

        // R9: read and write together
        put('h100, 32'h0000_0005);
        point('h100);
        op(0, 0, 1, 32'h0000_0006, 1, 0, 0, "R9 read old byte");
        op(0, 0, 0, 0, 1, 0, 0, "R9 new byte stored");

        // R1: load in same cycle as access
        put('h101, 32'h0000_0066);
        point('h100);
        op(1, 'h101, 0, 0, 1, 0, 0, "R1 read uses old pointer");
        op(0, 0, 0, 0, 1, 0, 0, "R1 new pointer");
        op(1, 'h102, 1, 32'h0000_0017, 0, 0, 0, "");
        get('h101, "R1 write used old pointer");

        // R7: back-to-back reads, then idle
        point('h380);
        op(0, 0, 0, 0, 1, 0, 0, "R7 back to back a");
        op(0, 0, 0, 0, 1, 0, 0, "R7 back to back b");
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R7 all reads answered", exp_q.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule